// File: doc/BRIEF.md
# Matrix Staging Buffer and Stream Feeder

This block sits between a processor's register port and a matrix pipeline. Software writes 32-bit words into a staging store that holds up to eight matrices. Each matrix has its own slot of 32 words. Software then writes a matrix count, and the block streams that many matrices downstream, one wide word per matrix, starting from slot 0.

The downstream side is a valid/ready stream. The ready input means the first pipeline stage can accept a matrix. Once a transfer starts, `mtx_valid` rises and stays high until the last matrix has been taken. A matrix is handed over in every cycle in which `mtx_valid` and `mtx_ready` are both high. While `mtx_ready` is low, the block holds `mtx_data` steady on the same slot, so back-pressure can last for any number of cycles. The `busy` output can be polled to see whether sending is still in progress.

For the 5×5 default, the wide word packs the 25 elements in row-major order. The element at row r and column c (both counted from zero) sits at index k = 5r + c, in bits 32k+31 down to 32k. The last seven words of each slot are stored but never sent.

Top module: `mtx_feeder`

## Requirements
- R1: After reset, `busy` and `mtx_valid` are 0.
- R2: A CPU write to address `a` stores the word as word `a[4:0]` of slot `a[7:5]`. While slot s is presented, bits 32k+31:32k of `mtx_data` equal word k of slot s, for k = 0..24.
- R3: A count write with a value n from 1 to 8 while idle makes `busy` and `mtx_valid` high from the next cycle on, presenting slot 0.
- R4: A count above 8 sends exactly 8 matrices.
- R5: A count of 0 has no effect: `busy` stays 0.
- R6: While `mtx_valid` is high and `mtx_ready` is low, `mtx_valid` stays high and `mtx_data` does not change.
- R7: Each cycle with `mtx_valid` and `mtx_ready` both high transfers one matrix and moves to the next slot. After exactly n transfers, `busy` and `mtx_valid` are 0 in the following cycle.
- R8: A count write while `busy` is high is ignored. The number of matrices sent and the slot order are unchanged.
- R9: Words 25 to 31 of a slot never reach `mtx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Staging word write strobe |
| cpu_addr | input | 8 | Staging word address (slot, word) |
| cpu_wdata | input | 32 | Staging word data |
| cnt_we | input | 1 | Count register write strobe (start) |
| cnt_val | input | 8 | Number of matrices to send |
| busy | output | 1 | Sending in progress |
| mtx_valid | output | 1 | Stream valid |
| mtx_ready | input | 1 | Stream ready (first stage free) |
| mtx_data | output | 800 | Packed matrix, row-major |

## Verification
The hardest situation to reach is a count write that arrives while a transfer is stalled mid-stream. It must change neither the remaining count nor the slot pointer. The stimulus creates this on purpose: it drops ready and issues a count write in the same cycle, inside a job that is already running. Random ready patterns with several duty cycles then check that each slot appears exactly once, in order, and is held through every stall.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int WORD_W     = 32;
  localparam int SLOT_WORDS = 32;
  localparam int SLOTS      = 8;
  localparam int MAT_N      = 5;
  localparam int CNTIN_W    = 8;
endpackage

// File: rtl/mtx_stage_mem.sv
module mtx_stage_mem #(
  parameter int WORD_W     = mtx_pkg::WORD_W,
  parameter int SLOT_WORDS = mtx_pkg::SLOT_WORDS,
  parameter int SLOTS      = mtx_pkg::SLOTS,
  parameter int ELEMS      = mtx_pkg::MAT_N * mtx_pkg::MAT_N,
  localparam int WOFF_W    = $clog2(SLOT_WORDS),
  localparam int PTR_W     = $clog2(SLOTS),
  localparam int ADDR_W    = WOFF_W + PTR_W
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [PTR_W-1:0]        rslot,
  output logic [ELEMS*WORD_W-1:0] rrow
);
  logic [WORD_W-1:0] store [SLOTS][SLOT_WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr[ADDR_W-1:WOFF_W]][waddr[WOFF_W-1:0]] <= wdata;
  end

  // Only the first ELEMS words of a slot are packed; the tail is padding.
  for (genvar k = 0; k < ELEMS; k++) begin : g_pack
    assign rrow[k*WORD_W +: WORD_W] = store[rslot][k];
  end
endmodule

// File: rtl/mtx_feed_ctrl.sv
module mtx_feed_ctrl #(
  parameter int SLOTS   = mtx_pkg::SLOTS,
  parameter int CNTIN_W = mtx_pkg::CNTIN_W,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_we,
  input  logic [CNTIN_W-1:0] cnt_val,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               busy,
  output logic [PTR_W-1:0]   slot
);
  logic             run;
  logic [CNT_W-1:0] remain;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] clamped;
  logic             start, fire;

  assign clamped = (cnt_val > CNTIN_W'(SLOTS)) ? CNT_W'(SLOTS) : CNT_W'(cnt_val);
  assign start   = cnt_we && !run && (cnt_val != '0);
  assign fire    = run && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      remain <= '0;
      ptr    <= '0;
    end else if (start) begin
      run    <= 1'b1;
      remain <= clamped;
      ptr    <= '0;
    end else if (fire) begin
      ptr    <= ptr + 1'b1;
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) run <= 1'b0;
    end
  end

  assign out_valid = run;
  assign busy      = run;
  assign slot      = ptr;

  AST_START_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ptr == '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (remain != '0 && remain <= CNT_W'(SLOTS))); // R4
  AST_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && cnt_we && cnt_val == '0) |=> !run); // R5
  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !out_ready) |=> (run && $stable(ptr))); // R6
  AST_NEXT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && remain != CNT_W'(1)) |=> (run && ptr == PTR_W'($past(ptr) + 1'b1))); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_we && !out_ready) |=> $stable(remain)); // R8
endmodule

// File: rtl/mtx_feeder.sv
module mtx_feeder #(
  parameter int WORD_W     = mtx_pkg::WORD_W,
  parameter int SLOT_WORDS = mtx_pkg::SLOT_WORDS,
  parameter int SLOTS      = mtx_pkg::SLOTS,
  parameter int MAT_N      = mtx_pkg::MAT_N,
  parameter int CNTIN_W    = mtx_pkg::CNTIN_W,
  localparam int ELEMS     = MAT_N * MAT_N,
  localparam int PTR_W     = $clog2(SLOTS),
  localparam int ADDR_W    = $clog2(SLOT_WORDS) + PTR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  input  logic                    cnt_we,
  input  logic [CNTIN_W-1:0]      cnt_val,
  output logic                    busy,
  output logic                    mtx_valid,
  input  logic                    mtx_ready,
  output logic [ELEMS*WORD_W-1:0] mtx_data
);
  logic [PTR_W-1:0] cur_slot;

  mtx_stage_mem #(
    .WORD_W(WORD_W), .SLOT_WORDS(SLOT_WORDS), .SLOTS(SLOTS), .ELEMS(ELEMS)
  ) u_mem (
    .clk(clk), .we(cpu_we), .waddr(cpu_addr), .wdata(cpu_wdata),
    .rslot(cur_slot), .rrow(mtx_data)
  );

  mtx_feed_ctrl #(.SLOTS(SLOTS), .CNTIN_W(CNTIN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .out_ready(mtx_ready), .out_valid(mtx_valid), .busy(busy), .slot(cur_slot)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cnt_we && cnt_val != '0)) |=> !mtx_valid); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mtx_valid && !mtx_ready && !cpu_we) |=> $stable(mtx_data)); // R6
endmodule

// File: tb/tb_mtx_feeder.sv
module tb_mtx_feeder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_we = 1'b0;
  logic [7:0]   cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cnt_we = 1'b0;
  logic [7:0]   cnt_val = '0;
  logic         busy, mtx_valid;
  logic         mtx_ready = 1'b0;
  logic [799:0] mtx_data;

  logic [31:0] shadow [256];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mtx_feeder dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cnt_we(cnt_we), .cnt_val(cnt_val), .busy(busy),
    .mtx_valid(mtx_valid), .mtx_ready(mtx_ready), .mtx_data(mtx_data)
  );

  function automatic logic [799:0] exp_row(input int s);
    logic [799:0] r;
    for (int k = 0; k < 25; k++) r[k*32 +: 32] = shadow[s*32 + k];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [799:0] act, input logic [799:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 8'(a); cpu_wdata = d;
    shadow[a] = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic run_job(input int n, input int pct, input bit poke);
    int expn, idx, guard;
    bit rdy;
    expn = (n == 0) ? 0 : ((n > 8) ? 8 : n);
    @(negedge clk);
    cnt_we = 1'b1; cnt_val = 8'(n);
    @(negedge clk);
    cnt_we = 1'b0;
    idx = 0; guard = 0;
    while (idx < expn && guard < 2000) begin
      guard++;
      rdy = (($urandom % 100) < pct);
      if (poke && idx == 1 && guard < 4) begin
        rdy = 1'b0; cnt_we = 1'b1; cnt_val = 8'd3;  // R8 stalled count write
      end
      mtx_ready = rdy;
      #1;
      chk("R3/R6 valid held", {799'b0, mtx_valid}, 800'd1);
      chk("R2/R7/R9 slot data", mtx_data, exp_row(idx));
      @(posedge clk);
      if (rdy) idx++;
      @(negedge clk);
      cnt_we = 1'b0;
    end
    mtx_ready = 1'b0;
    #1;
    chk("R7/R8/R4/R5 busy after job", {799'b0, busy}, 800'd0);
    chk("R7 valid after job", {799'b0, mtx_valid}, 800'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 busy at reset", {799'b0, busy}, 800'd0);
    chk("R1 valid at reset", {799'b0, mtx_valid}, 800'd0);
    for (int a = 0; a < 256; a++) wr(a, $urandom);
    run_job(3, 100, 1'b0);                 // R3 full-rate
    run_job(0, 50, 1'b0);                  // R5 zero count
    run_job(8, 30, 1'b0);                  // R6 heavy back-pressure
    run_job(12, 70, 1'b0);                 // R4 clamp to 8
    run_job(5, 60, 1'b1);                  // R8 count write while busy
    for (int w = 25; w < 32; w++) wr(w, $urandom);  // R9 tail words
    wr(7, 32'hCAFE_0007);                  // R2 element (1,2) of slot 0
    run_job(2, 40, 1'b0);                  // R3 restarts at slot 0
    for (int j = 0; j < 4; j++) run_job(1 + ($urandom % 9), 20 + ($urandom % 80), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule